// File: doc/BRIEF.md
# Port-Mapped Register Hub with Interrupt Request

This block sits on the I/O side of a small 8-bit controller. The controller drives an 8-bit port address, an 8-bit write data byte, a write strobe and a read strobe. The hub decodes the address to load one of several output registers, or to pick the byte it returns on the read data bus. The address stays steady for two cycles of every transfer, so the read bus is a purely combinational selection that is settled before the read strobe comes.

Event inputs from the surrounding logic set sticky bits in a status register. Reading that status register clears it. Any event also raises an interrupt request to the controller. The request is held for at least two cycles, so the controller is sure to see it. After that it stays high until the controller sends an acknowledge.

The request is handled by a three-state machine. `IRQ_IDLE` means nothing is pending. From there, an event takes it to `IRQ_FRESH`, the first cycle of the request. From `IRQ_FRESH` it always moves to `IRQ_PENDING`, and it ignores any acknowledge in that cycle. In `IRQ_PENDING`, an acknowledge with no event in the same cycle returns it to `IRQ_IDLE`. In every other case it stays in `IRQ_PENDING`.

Top module: `port_hub`

## Requirements
- R1: After a synchronous reset, all output registers are 0x00, the status bits are 0 and `irq` is low.
- R2: When `wr_stb` is high and `port_addr` is 0x00 to 0x03, the output register with that index takes `wr_data` at the clock edge. The other output registers are unchanged.
- R3: A write to any address outside 0x00 to 0x03, or any cycle with `wr_stb` low, leaves every output register unchanged.
- R4: `rd_data` follows `port_addr` in the same cycle, with no dependence on `rd_stb`. Address 0x10+j returns byte j of `ext_in` (j = 0, 1). Address 0x00+i returns output register i.
- R5: Address 0x20 returns the status bits in bits 3:0 of `rd_data`, with bits 7:4 zero. Any address that is not mapped returns 0x00.
- R6: When `evt_in` bit k is high at a clock edge, status bit k is set from the next cycle on. It stays set until it is cleared by a read.
- R7: When `rd_stb` is high with `port_addr` at 0x20, the status register is replaced by that cycle's `evt_in`. An event in the same cycle as the read is therefore kept. A read strobe at any other address leaves the status bits unchanged.
- R8: With no request pending, an event makes `irq` go high at the next edge. `irq` then stays high for at least two cycles, even if `irq_ack` is high in the first of them.
- R9: Once `irq` has been high for two or more cycles, it falls at the next edge only if `irq_ack` is high and no event is present. Without an acknowledge, `irq` stays high.
- R10: An event that arrives while a request is pending, including one in the same cycle as `irq_ack`, keeps `irq` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_addr | input | 8 | Port address from the controller |
| wr_data | input | 8 | Write data byte |
| wr_stb | input | 1 | Write strobe, marks `wr_data` as valid |
| rd_stb | input | 1 | Read strobe, marks the cycle in which the controller takes `rd_data` |
| ext_in | input | 16 | Two external input bytes |
| evt_in | input | 4 | Event inputs, high for one cycle per event |
| irq_ack | input | 1 | Interrupt acknowledge from the controller |
| rd_data | output | 8 | Read data selected by `port_addr` |
| out_regs | output | 32 | Four output registers, register i in bits 8i+7:8i |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after an acknowledge that arrives in the first request cycle. A design that honours it would drop `irq` after a single cycle. The bench also drives an event in the same cycle as an acknowledge, where a careless clear would lose the event and leave it with no request. A status read is made while a new event is present, which catches a clear that also erases that event. Writes and read strobes at unmapped or other addresses would show up as corrupted registers or status bits that vanish.

// File: rtl/port_hub_pkg.sv
package port_hub_pkg;
    typedef enum logic [1:0] {
        IRQ_IDLE    = 2'd0,
        IRQ_FRESH   = 2'd1,
        IRQ_PENDING = 2'd2
    } irq_state_t;
endpackage

// File: rtl/port_hub_outregs.sv
module port_hub_outregs #(
    parameter int N_OUT    = 4,
    parameter int OUT_BASE = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         port_addr,
    input  logic [7:0]         wr_data,
    input  logic               wr_stb,
    output logic [N_OUT*8-1:0] out_regs
);
    logic [N_OUT-1:0][7:0] regs_q;

    for (genvar i = 0; i < N_OUT; i++) begin : g_reg
        localparam logic [7:0] ADDR = 8'(OUT_BASE + i);
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= '0;
            else if (wr_stb && port_addr == ADDR)
                regs_q[i] <= wr_data;
        end
        assign out_regs[i*8 +: 8] = regs_q[i];
    end

    // R3: registers hold whenever no write strobe is present
    p_hold_no_write_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(out_regs));
endmodule

// File: rtl/port_hub_status.sv
module port_hub_status #(
    parameter int N_EVT     = 4,
    parameter int STAT_ADDR = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       port_addr,
    input  logic             rd_stb,
    input  logic [N_EVT-1:0] evt_in,
    output logic [N_EVT-1:0] status
);
    localparam logic [7:0] SADDR = 8'(STAT_ADDR);

    logic clr_read;
    assign clr_read = rd_stb && (port_addr == SADDR);

    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else if (clr_read)
            status <= evt_in;
        else
            status <= status | evt_in;
    end

    // R6: every event seen at an edge is present in the status afterwards
    p_event_sticks_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(evt_in)) == $past(evt_in)));
    // R7: a read with no simultaneous event empties the status
    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_read && evt_in == '0) |=> (status == '0));
endmodule

// File: rtl/port_hub_irq.sv
module port_hub_irq
    import port_hub_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt_any,
    input  logic irq_ack,
    output logic irq
);
    irq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= IRQ_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (evt_any) state_d = IRQ_FRESH;
            IRQ_FRESH:   state_d = IRQ_PENDING;
            IRQ_PENDING: if (irq_ack && !evt_any) state_d = IRQ_IDLE;
            default:     state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q != IRQ_IDLE);
    end

    // R8: a fresh request lasts at least two cycles
    p_min_two_cycles_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |=> irq);
    // R9: a falling request was acknowledged in the previous cycle
    p_fall_needs_ack_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(irq_ack));
    // R10: an event while pending keeps the request up
    p_event_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && evt_any) |=> irq);
    // R9: a matured request with ack and no event drops
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(irq) && irq_ack && !evt_any) |=> !irq);
endmodule

// File: rtl/port_hub.sv
module port_hub #(
    parameter int N_OUT     = 4,
    parameter int N_IN      = 2,
    parameter int N_EVT     = 4,
    parameter int OUT_BASE  = 0,
    parameter int IN_BASE   = 16,
    parameter int STAT_ADDR = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         port_addr,
    input  logic [7:0]         wr_data,
    input  logic               wr_stb,
    input  logic               rd_stb,
    input  logic [N_IN*8-1:0]  ext_in,
    input  logic [N_EVT-1:0]   evt_in,
    input  logic               irq_ack,
    output logic [7:0]         rd_data,
    output logic [N_OUT*8-1:0] out_regs,
    output logic               irq
);
    logic [N_EVT-1:0] status;

    port_hub_outregs #(.N_OUT(N_OUT), .OUT_BASE(OUT_BASE)) u_outregs (
        .clk(clk), .rst(rst), .port_addr(port_addr), .wr_data(wr_data),
        .wr_stb(wr_stb), .out_regs(out_regs)
    );

    port_hub_status #(.N_EVT(N_EVT), .STAT_ADDR(STAT_ADDR)) u_status (
        .clk(clk), .rst(rst), .port_addr(port_addr), .rd_stb(rd_stb),
        .evt_in(evt_in), .status(status)
    );

    port_hub_irq u_irq (
        .clk(clk), .rst(rst), .evt_any(|evt_in), .irq_ack(irq_ack), .irq(irq)
    );

    // R4/R5 read selection, settled before the read strobe
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < N_OUT; i++)
            if (port_addr == 8'(OUT_BASE + i)) rd_data = out_regs[i*8 +: 8];
        for (int j = 0; j < N_IN; j++)
            if (port_addr == 8'(IN_BASE + j)) rd_data = ext_in[j*8 +: 8];
        if (port_addr == 8'(STAT_ADDR)) rd_data = 8'(status);
    end
endmodule

// File: tb/port_hub_bench.sv
module port_hub_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  port_addr = 0, wr_data = 0;
    logic        wr_stb = 0, rd_stb = 0, irq_ack = 0;
    logic [15:0] ext_in = 0;
    logic [3:0]  evt_in = 0;
    logic [7:0]  rd_data;
    logic [31:0] out_regs;
    logic        irq;

    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    port_hub u_port_hub (.*);

    // behavioural reference
    logic [7:0] m_out [4];
    logic [3:0] m_stat;
    int         m_age;   // 0 none, 1 first request cycle, 2 matured

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) m_out[i] <= 0;
            m_stat <= 0;
            m_age  <= 0;
        end else begin
            if (wr_stb && port_addr < 4) m_out[port_addr[1:0]] <= wr_data;
            if (rd_stb && port_addr == 8'h20) m_stat <= evt_in;
            else m_stat <= m_stat | evt_in;
            if (m_age == 0 && evt_in != 0) m_age <= 1;
            else if (m_age == 1) m_age <= 2;
            else if (m_age == 2 && irq_ack && evt_in == 0) m_age <= 0;
        end
    end

    function automatic logic [7:0] exp_rd();
        if (port_addr < 4) return m_out[port_addr[1:0]];
        if (port_addr == 8'h10) return ext_in[7:0];
        if (port_addr == 8'h11) return ext_in[15:8];
        if (port_addr == 8'h20) return {4'h0, m_stat};
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R9 irq vs model", {31'b0, irq}, {31'b0, m_age != 0});
        chk("R2 out_regs vs model", out_regs, {m_out[3], m_out[2], m_out[1], m_out[0]});
        chk("R4 rd_data vs model", {24'b0, rd_data}, {24'b0, exp_rd()});
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        wr_stb = 0; rd_stb = 0; irq_ack = 0; evt_in = 0;
    endtask

    task automatic write(input logic [7:0] a, input logic [7:0] d);
        port_addr = a; wr_data = d; wr_stb = 1; cyc();
        wr_stb = 0; cyc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_regs reset", out_regs, 0);
        chk("R1 irq reset", {31'b0, irq}, 0);
        port_addr = 8'h20;
        #1 chk("R1 status reset", {24'b0, rd_data}, 0);
        rst = 0;
        cyc();

        // R2 writes, R3 unmapped writes
        write(8'h00, 8'hA1); write(8'h01, 8'hB2); write(8'h02, 8'hC3); write(8'h03, 8'hD4);
        chk("R2 all four registers", out_regs, 32'hD4C3B2A1);
        write(8'h04, 8'h55); write(8'h20, 8'h66); write(8'hFF, 8'h77);
        chk("R3 unmapped writes ignored", out_regs, 32'hD4C3B2A1);
        port_addr = 8'h02; wr_data = 8'h99; cyc();
        chk("R3 no strobe no load", out_regs, 32'hD4C3B2A1);

        // R4 combinational reads
        ext_in = 16'h3C5A;
        port_addr = 8'h10; #1 chk("R4 ext byte 0", {24'b0, rd_data}, 32'h5A);
        port_addr = 8'h11; #1 chk("R4 ext byte 1", {24'b0, rd_data}, 32'h3C);
        port_addr = 8'h01; #1 chk("R4 register readback", {24'b0, rd_data}, 32'hB2);
        port_addr = 8'h30; #1 chk("R5 unmapped reads zero", {24'b0, rd_data}, 0);
        cyc();

        // R6, R8: event sets status and starts a request; early ack ignored
        evt_in = 4'b0010; cyc();
        evt_in = 0; irq_ack = 1;
        chk("R8 irq rises after event", {31'b0, irq}, 1);
        cyc();
        irq_ack = 0;
        chk("R8 early ack ignored", {31'b0, irq}, 1);
        port_addr = 8'h20; #1 chk("R6 status bit set", {24'b0, rd_data}, 32'h02);
        repeat (3) cyc();
        chk("R9 held without ack", {31'b0, irq}, 1);
        irq_ack = 1; evt_in = 4'b0100; cyc();
        chk("R10 event with ack keeps irq", {31'b0, irq}, 1);
        evt_in = 0; cyc();
        irq_ack = 0;
        chk("R9 ack clears irq", {31'b0, irq}, 0);
        port_addr = 8'h20; #1 chk("R6 status sticky", {24'b0, rd_data}, 32'h06);

        // R7: read at other address, then clear-on-read with a new event
        port_addr = 8'h10; rd_stb = 1; cyc();
        port_addr = 8'h20; #1 chk("R7 other read keeps status", {24'b0, rd_data}, 32'h06);
        rd_stb = 1; evt_in = 4'b1000; cyc();
        idle();
        #1 chk("R7 read clears, keeps new event", {24'b0, rd_data}, 32'h08);
        rd_stb = 1; cyc();
        idle();
        #1 chk("R7 read empties status", {24'b0, rd_data}, 0);
        irq_ack = 1; repeat (2) cyc(); idle(); cyc();

        // random traffic compared every cycle
        for (int n = 0; n < 400; n++) begin
            port_addr = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 6 + (($urandom % 2) ? 8'h10 : 0));
            if ($urandom % 5 == 0) port_addr = 8'h20;
            wr_data = 8'($urandom);
            wr_stb  = ($urandom % 3 == 0);
            rd_stb  = ($urandom % 3 == 0);
            evt_in  = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
            irq_ack = ($urandom % 4 == 0);
            ext_in  = 16'($urandom);
            cyc();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule